// File: doc/BRIEF.md
# Co-issue Utilization Statistics Unit

This block sits beside the issue stage of one core whose execution lanes are split into a number of equal sets. On every cycle in which partitioning is enabled and a composite instruction leaves the issue stage, it looks at the composite's per-set valid bits and per-set lane masks. It counts those cycles, adds the number of active lanes in valid sets to a running total, and bumps one bin of a histogram indexed by how many sets the composite occupied.

Alongside the composite sampling it keeps five event counters. Two count co-issues: one for candidates taken from other warps and one for candidates taken from divergent splits of the same warp. Three count rejected candidates, each charged to one cause: a functional-unit mismatch, a scoreboard hazard, or too few free sets. Several candidates can be judged in one cycle, so each event input carries an amount rather than a single strobe. A one-cycle read port selects any counter or histogram bin by index. Software computes the average lanes per composite cycle from two of the counters, taking zero when the cycle count is zero.

Top module: `coissue_stats`

## Requirements
- R1: After reset every counter and histogram bin is zero and `rd_data` is zero.
- R2: Composite statistics (cycle count, lane total, histogram) change only in cycles where `part_en` and `comp_valid` are both 1; in any other cycle the set inputs have no effect.
- R3: Each qualifying cycle adds one to the composite-cycle counter (read index 0).
- R4: Each qualifying cycle adds to the lane total (read index 1) the number of 1 bits in the lane masks of sets whose valid bit is 1; set s owns bits [s*SET_LANES +: SET_LANES] of `set_lanes`, and masks of invalid sets are ignored.
- R5: The histogram has NUM_SETS+1 bins at read indices 7 to 7+NUM_SETS; a qualifying cycle with k valid sets adds one to bin k, and a count of NUM_SETS+1 or more would be clamped into the last bin.
- R6: Every cycle, the amounts on `inter_inc`, `intra_inc`, `deny_fu_inc`, `deny_sb_inc` and `deny_ns_inc` (each 0 to MAX_CANDS) are added to the counters at read indices 2, 3, 4, 5 and 6, whether or not the cycle qualifies.
- R7: Every counter is CNT_W bits (64 by default) and stops at all ones instead of wrapping.
- R8: A 1 on `clr` at a clock edge zeroes every counter and bin, and wins over any increment presented in the same cycle.
- R9: `rd_data` shows, one edge after `rd_idx` is presented, the selected value as it stood before that edge's update; an index of 7+NUM_SETS+1 or more returns zero.
- R10: With NUM_SETS = 1 (partitioning off) the histogram has exactly two bins, at indices 7 and 8, and index 9 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| part_en | input | 1 | Lane partitioning enabled |
| comp_valid | input | 1 | A composite instruction issues this cycle |
| set_valid | input | NUM_SETS | Per-set occupied bits of the composite |
| set_lanes | input | NUM_SETS*SET_LANES | Per-set lane masks of the composite |
| inter_inc | input | EV_W | Inter-warp co-issues this cycle |
| intra_inc | input | EV_W | Intra-warp co-issues this cycle |
| deny_fu_inc | input | EV_W | Candidates rejected for unit mismatch |
| deny_sb_inc | input | EV_W | Candidates rejected for scoreboard hazard |
| deny_ns_inc | input | EV_W | Candidates rejected for lack of free sets |
| rd_idx | input | IDX_W | Counter or bin select |
| rd_data | output | CNT_W | Selected value, one cycle later |

## Verification
A read and an update of the same counter can fall on the same edge, and so can a clear and an increment. The bench presents `rd_idx` for the composite-cycle counter in the very cycle a qualifying composite arrives and expects the old total on the next sample, then the new total one edge later. It also raises `clr` together with a qualifying composite and a co-issue amount and expects zero in every affected counter afterwards.

// File: rtl/coissue_stats_pkg.sv
package coissue_stats_pkg;
  // Read-port layout; histogram bins follow from IX_BIN0 upward.
  localparam int IX_CYC     = 0;
  localparam int IX_LANES   = 1;
  localparam int IX_INTER   = 2;
  localparam int IX_INTRA   = 3;
  localparam int IX_DENY_FU = 4;
  localparam int IX_DENY_SB = 5;
  localparam int IX_DENY_NS = 6;
  localparam int IX_BIN0    = 7;

  function automatic int num_slots(input int nsets);
    return IX_BIN0 + nsets + 1;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cs_sample.sv
module cs_sample #(
  parameter int NUM_SETS  = 4,
  parameter int SET_LANES = 8,
  parameter int LSUM_W    = 6,
  parameter int USED_W    = 3,
  parameter int NBINS     = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          part_en,
  input  logic                          comp_valid,
  input  logic [NUM_SETS-1:0]           set_valid,
  input  logic [NUM_SETS*SET_LANES-1:0] set_lanes,
  output logic                          sample,
  output logic [LSUM_W-1:0]             lane_sum,
  output logic [NBINS-1:0]              bin_hit
);
  function automatic logic [USED_W-1:0] count_sets(input logic [NUM_SETS-1:0] v);
    logic [USED_W-1:0] n;
    n = '0;
    for (int s = 0; s < NUM_SETS; s++)
      if (v[s]) n = n + USED_W'(1);
    return n;
  endfunction

  function automatic logic [LSUM_W-1:0] count_lanes(
      input logic [NUM_SETS-1:0] v, input logic [NUM_SETS*SET_LANES-1:0] m);
    logic [LSUM_W-1:0] n;
    n = '0;
    for (int s = 0; s < NUM_SETS; s++)
      for (int b = 0; b < SET_LANES; b++)
        if (v[s] && m[s*SET_LANES+b]) n = n + LSUM_W'(1);
    return n;
  endfunction

  function automatic logic [USED_W-1:0] clamp_bin(input logic [USED_W-1:0] u);
    return (int'(u) >= NBINS) ? USED_W'(NBINS-1) : u;
  endfunction

  logic [USED_W-1:0] used_sets;
  logic [USED_W-1:0] bin_idx;

  assign sample    = part_en & comp_valid;
  assign used_sets = count_sets(set_valid);
  assign bin_idx   = clamp_bin(used_sets);
  assign lane_sum  = sample ? count_lanes(set_valid, set_lanes) : '0;

  for (genvar k = 0; k < NBINS; k++) begin : g_bin
    assign bin_hit[k] = sample && (bin_idx == USED_W'(k));
  end

  // R5: a qualifying cycle lands in exactly one bin
  p_one_bin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bin_hit) == (sample ? 1 : 0));
  // R4: no more lanes than the occupied sets can hold
  p_lanes_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lane_sum) <= int'(used_sets) * SET_LANES);
  // R2: non-qualifying cycles feed nothing into composite statistics
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |-> (lane_sum == '0 && bin_hit == '0));
endmodule

// File: rtl/cs_counter.sv
module cs_counter #(
  parameter int CNT_W = 64,
  parameter int INC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);
  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                                input logic [INC_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W+1)'(b);
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= sat_add(cnt, inc);
  end

  // R8: clear empties the counter whatever the increment
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  // R7: a full counter stays full
  p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == '1) |=> cnt == '1);
  // R7: without clear the count never goes down (no wrap)
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt >= $past(cnt));
endmodule

// File: rtl/cs_readmux.sv
module cs_readmux #(
  parameter int NCNT  = 12,
  parameter int CNT_W = 64,
  parameter int IDX_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCNT-1:0][CNT_W-1:0] cval,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [CNT_W-1:0]           rd_data
);
  logic [CNT_W-1:0] sel;
  logic             in_range;

  always_comb begin
    sel      = '0;
    in_range = 1'b0;
    for (int i = 0; i < NCNT; i++)
      if (rd_idx == IDX_W'(i)) begin
        sel      = cval[i];
        in_range = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= sel;
  end

  // R9: an index past the last bin reads zero
  p_oob_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |=> rd_data == '0);
endmodule

// File: rtl/coissue_stats.sv
module coissue_stats
  import coissue_stats_pkg::*;
#(
  parameter int NUM_SETS  = 4,
  parameter int SET_LANES = 8,
  parameter int CNT_W     = 64,
  parameter int MAX_CANDS = 3,
  parameter int EV_W      = $clog2(MAX_CANDS + 1),
  parameter int IDX_W     = $clog2(num_slots(NUM_SETS))
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          part_en,
  input  logic                          comp_valid,
  input  logic [NUM_SETS-1:0]           set_valid,
  input  logic [NUM_SETS*SET_LANES-1:0] set_lanes,
  input  logic [EV_W-1:0]               inter_inc,
  input  logic [EV_W-1:0]               intra_inc,
  input  logic [EV_W-1:0]               deny_fu_inc,
  input  logic [EV_W-1:0]               deny_sb_inc,
  input  logic [EV_W-1:0]               deny_ns_inc,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [CNT_W-1:0]              rd_data
);
  localparam int NBINS  = NUM_SETS + 1;
  localparam int NCNT   = num_slots(NUM_SETS);
  localparam int LSUM_W = $clog2(NUM_SETS * SET_LANES + 1);
  localparam int USED_W = $clog2(NUM_SETS + 1);
  localparam int INC_W  = max2(LSUM_W, EV_W);

  logic                       sample;
  logic [LSUM_W-1:0]          lane_sum;
  logic [NBINS-1:0]           bin_hit;
  logic [NCNT-1:0][INC_W-1:0] inc;
  logic [NCNT-1:0][CNT_W-1:0] cval;

  cs_sample #(
    .NUM_SETS(NUM_SETS), .SET_LANES(SET_LANES), .LSUM_W(LSUM_W),
    .USED_W(USED_W), .NBINS(NBINS)
  ) u_sample (
    .clk(clk), .rst_n(rst_n), .part_en(part_en), .comp_valid(comp_valid),
    .set_valid(set_valid), .set_lanes(set_lanes),
    .sample(sample), .lane_sum(lane_sum), .bin_hit(bin_hit)
  );

  always_comb begin
    inc             = '0;
    inc[IX_CYC]     = INC_W'(sample);
    inc[IX_LANES]   = INC_W'(lane_sum);
    inc[IX_INTER]   = INC_W'(inter_inc);
    inc[IX_INTRA]   = INC_W'(intra_inc);
    inc[IX_DENY_FU] = INC_W'(deny_fu_inc);
    inc[IX_DENY_SB] = INC_W'(deny_sb_inc);
    inc[IX_DENY_NS] = INC_W'(deny_ns_inc);
    for (int k = 0; k < NBINS; k++)
      inc[IX_BIN0+k] = INC_W'(bin_hit[k]);
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    cs_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc[i]), .cnt(cval[i])
    );
  end

  cs_readmux #(.NCNT(NCNT), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .cval(cval), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // R6: event amounts stay within the candidates judged per cycle
  p_event_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(inter_inc) <= MAX_CANDS && int'(intra_inc) <= MAX_CANDS &&
    int'(deny_fu_inc) <= MAX_CANDS && int'(deny_sb_inc) <= MAX_CANDS &&
    int'(deny_ns_inc) <= MAX_CANDS);
  // R1: read port is quiet right after reset
  p_reset_read_r1: assert property (@(posedge clk)
    !rst_n |=> rd_data == '0);
endmodule

// File: tb/sim_coissue_stats.sv
module sim_coissue_stats;
  localparam int NS = 4, SL = 8, CW = 8, MC = 3, EW = 2, IW = 4, NV = 6;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic pe = 1'b0, cv = 1'b0;
  logic [NS-1:0] sv = '0;
  logic [NS*SL-1:0] ln = '0;
  logic [EW-1:0] e_inter = '0, e_intra = '0, e_fu = '0, e_sb = '0, e_ns = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [CW-1:0] rd_data;

  logic b_pe = 1'b0, b_cv = 1'b0;
  logic [0:0] b_sv = '0;
  logic [7:0] b_ln = '0;
  logic [IW-1:0] b_idx = '0;
  logic [CW-1:0] b_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  coissue_stats #(.NUM_SETS(NS), .SET_LANES(SL), .CNT_W(CW), .MAX_CANDS(MC)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .part_en(pe), .comp_valid(cv),
    .set_valid(sv), .set_lanes(ln), .inter_inc(e_inter), .intra_inc(e_intra),
    .deny_fu_inc(e_fu), .deny_sb_inc(e_sb), .deny_ns_inc(e_ns),
    .rd_idx(rd_idx), .rd_data(rd_data));

  coissue_stats #(.NUM_SETS(1), .SET_LANES(8), .CNT_W(CW), .MAX_CANDS(MC)) u1 (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .part_en(b_pe), .comp_valid(b_cv),
    .set_valid(b_sv), .set_lanes(b_ln), .inter_inc(2'd0), .intra_inc(2'd0),
    .deny_fu_inc(2'd0), .deny_sb_inc(2'd0), .deny_ns_inc(2'd0),
    .rd_idx(b_idx), .rd_data(b_data));

  // stimulus columns
  localparam logic        V_PE [NV] = '{1, 1, 0, 1, 1, 1};
  localparam logic        V_CV [NV] = '{1, 1, 1, 0, 1, 1};
  localparam logic [3:0]  V_SV [NV] = '{4'b0011, 4'b1111, 4'b1111, 4'b0001, 4'b0000, 4'b0100};
  localparam logic [31:0] V_LN [NV] = '{32'hFF00_01FF, 32'h0101_0101, 32'hFFFF_FFFF,
                                        32'h0000_00FF, 32'hFFFF_FFFF, 32'h00F0_0000};
  localparam int V_EV [NV][5] = '{'{1,0,0,1,0}, '{2,1,1,0,2}, '{0,0,3,0,0},
                                  '{0,2,0,0,1}, '{0,0,0,0,0}, '{1,0,0,2,0}};
  // expected: qualifies, sets used, lanes counted
  localparam int X_Q  [NV] = '{1, 1, 0, 0, 1, 1};
  localparam int X_US [NV] = '{2, 4, 0, 0, 0, 1};
  localparam int X_LN [NV] = '{9, 4, 0, 0, 0, 4};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    pe = 0; cv = 0; sv = '0; ln = '0; clr = 0;
    e_inter = 0; e_intra = 0; e_fu = 0; e_sb = 0; e_ns = 0;
  endtask

  task automatic rd(input int idx, output int v);
    @(negedge clk);
    idle();
    rd_idx = IW'(idx);
    @(posedge clk); #1;
    v = int'(rd_data);
  endtask

  task automatic rd_b(input int idx, output int v);
    @(negedge clk);
    b_pe = 0; b_cv = 0; b_sv = '0; b_ln = '0;
    b_idx = IW'(idx);
    @(posedge clk); #1;
    v = int'(b_data);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    int exp_c [12];
    for (int i = 0; i < 12; i++) exp_c[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset state
    rd(1, v);  chk("R1 lanes after reset", v, 0);
    rd(7, v);  chk("R1 bin0 after reset", v, 0);

    // table walk: R2 R3 R4 R5 R6
    for (int t = 0; t < NV; t++) begin
      @(negedge clk);
      pe = V_PE[t]; cv = V_CV[t]; sv = V_SV[t]; ln = V_LN[t];
      e_inter = EW'(V_EV[t][0]); e_intra = EW'(V_EV[t][1]);
      e_fu = EW'(V_EV[t][2]); e_sb = EW'(V_EV[t][3]); e_ns = EW'(V_EV[t][4]);
      exp_c[0] += X_Q[t];
      exp_c[1] += X_LN[t];
      for (int e = 0; e < 5; e++) exp_c[2+e] += V_EV[t][e];
      if (X_Q[t] != 0) exp_c[7 + X_US[t]] += 1;
      @(posedge clk);
    end
    for (int i = 0; i < 12; i++) begin
      rd(i, v);
      case (i)
        0: chk("R3 composite cycles", v, exp_c[i]);
        1: chk("R4 lane total", v, exp_c[i]);
        2, 3, 4, 5, 6: chk("R6 event counter", v, exp_c[i]);
        default: chk("R5 histogram bin", v, exp_c[i]);
      endcase
    end
    chk("R2 composite cycles skip gated vectors", exp_c[0], 4);

    // R9: out-of-range index
    rd(12, v); chk("R9 index 12 reads zero", v, 0);
    rd(15, v); chk("R9 index 15 reads zero", v, 0);

    // R9: read and update of the same counter on one edge
    @(negedge clk);
    idle(); pe = 1; cv = 1; sv = 4'b0001; ln = 32'h0000_0003; rd_idx = 0;
    @(posedge clk); #1;
    chk("R9 same-edge read shows old value", int'(rd_data), 4);
    rd(0, v); chk("R9 next read shows new value", v, 5);

    // R8: clear together with increments
    @(negedge clk);
    idle(); clr = 1; pe = 1; cv = 1; sv = 4'b1111; ln = '1; e_inter = 2;
    @(posedge clk);
    rd(0, v); chk("R8 cycles cleared", v, 0);
    rd(1, v); chk("R8 lanes cleared", v, 0);
    rd(2, v); chk("R8 inter cleared", v, 0);
    rd(11, v); chk("R8 bin4 cleared", v, 0);

    // R7: saturation of the lane total (9 x 32 lanes > 255)
    for (int n = 0; n < 9; n++) begin
      @(negedge clk);
      idle(); pe = 1; cv = 1; sv = 4'b1111; ln = '1;
      @(posedge clk);
    end
    rd(1, v);  chk("R7 lane total saturates", v, 255);
    rd(0, v);  chk("R7 cycles below limit", v, 9);
    rd(11, v); chk("R5 full composite in last bin", v, 9);
    @(negedge clk);
    idle(); pe = 1; cv = 1; sv = 4'b1111; ln = '1;
    @(posedge clk);
    rd(1, v);  chk("R7 saturated total holds", v, 255);

    // R10: single-set variant
    @(negedge clk);
    b_pe = 1; b_cv = 1; b_sv = 1'b1; b_ln = 8'h0F;
    @(posedge clk);
    @(negedge clk);
    b_pe = 1; b_cv = 1; b_sv = 1'b0; b_ln = 8'hFF;
    @(posedge clk);
    rd_b(1, v); chk("R10 single-set lanes", v, 4);
    rd_b(7, v); chk("R10 bin0", v, 1);
    rd_b(8, v); chk("R10 bin1", v, 1);
    rd_b(9, v); chk("R10 index 9 reads zero", v, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule